// File: doc/BRIEF.md
# Programmable Interval Timer with One-Shot and Periodic Modes

This block is a down-counter that advances on an external one-microsecond tick pulse and raises an interrupt when its programmed interval runs out. Software controls it through two 32-bit words selected by a one-bit word address. The control word starts, restarts or stops the timer, selects one-shot or auto-reload operation, and sets the interval. The status word returns the live counter value and the pending interrupt flag. Writing that word with the acknowledge bit set clears the flag.

An interval of N ticks is programmed as N-1. A programmed value of 0 therefore fires on the first tick after the load. In auto-reload mode the counter restarts from the programmed value each time it expires, so a value of 9999 gives a 100 Hz interrupt from a 1 MHz tick. In one-shot mode the timer switches itself off after the first expiry. The interrupt output is an active-high level that stays asserted until software acknowledges it.

Top module: `ivt_timer`

## Requirements
- R1: After reset, irq is low and reads of both words (reg_sel 0 and reg_sel 1) return 0.
- R2: A write with reg_sel=0 and wr_data[31]=1 starts the timer. Bit 30 selects auto-reload (1) or one-shot (0), and bits 28:0 are the interval. On the next cycle the control word reads back as {run, autoreload, 0, interval}, and status bits 28:0 hold the interval.
- R3: While the timer is running, the counter drops by one on each cycle where tick is high. It holds its value on cycles where tick is low.
- R4: With interval V, irq rises in the cycle after the (V+1)-th tick and not earlier.
- R5: In one-shot mode, expiry clears the run bit (control bit 31). The counter then stays at 0, and later ticks raise no new interrupt.
- R6: In auto-reload mode, expiry reloads the counter with the interval and the run bit stays set. Each further V+1 ticks raise irq again.
- R7: A write with reg_sel=0 and wr_data[31]=0 stops the timer. The counter freezes and later ticks raise no interrupt.
- R8: A write with reg_sel=1 and wr_data[30]=1 clears the pending flag. A write with reg_sel=1 and wr_data[30]=0 leaves it unchanged.
- R9: When an expiry and an acknowledge write fall in the same cycle, the flag stays set.
- R10: A start write reloads the counter even while the timer runs, including in a cycle where tick is high. The loaded value wins over the decrement.
- R11: irq is a level. It stays high from expiry until an acknowledge write.
- R12: Status reads carry the pending flag in bit 30 and the counter in bits 28:0. Control bit 29 is ignored on write and reads as 0. The interval 0x1FFFFFFF is held in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Word address: 0 control, 1 status/acknowledge |
| wr_en | input | 1 | Write strobe for the selected word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data of the selected word |
| tick | input | 1 | One-cycle count pulse (1 us) |
| irq | output | 1 | Active-high level interrupt |

## Verification
A wrong counter value shows up on the status word in the same cycle it is read, and it moves the irq rising edge by one or more ticks. Such a shift appears at the first expiry after the fault. A run or mode bit held wrongly shows in two ways: a second interrupt appears after a one-shot expiry, or a periodic timer falls silent. Either appears within one interval. A wrong pending flag is visible at irq on the cycle after the faulty update, for example when an acknowledge beats a same-cycle expiry.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
    localparam int DATA_W   = 32;
    localparam int RUN_BIT  = 31;
    localparam int MODE_BIT = 30;
    localparam int ACK_BIT  = 30;
    localparam int PEND_BIT = 30;
    localparam logic SEL_CTRL = 1'b0;
    localparam logic SEL_STAT = 1'b1;

    typedef struct packed {
        logic start;
        logic halt;
        logic autoreload;
        logic ack;
    } ivt_cmd_t;
endpackage

// File: rtl/ivt_bus_decode.sv
module ivt_bus_decode
    import ivt_pkg::*;
#(
    parameter int CNT_W = 29
) (
    input  logic              reg_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output ivt_cmd_t          cmd,
    output logic [CNT_W-1:0]  interval
);
    logic ctrl_wr;
    logic stat_wr;
    logic unused_bits;

    assign ctrl_wr = wr_en && (reg_sel == SEL_CTRL);
    assign stat_wr = wr_en && (reg_sel == SEL_STAT);

    always_comb begin
        cmd.start      = ctrl_wr && wr_data[RUN_BIT];
        cmd.halt       = ctrl_wr && !wr_data[RUN_BIT];
        cmd.autoreload = wr_data[MODE_BIT];
        cmd.ack        = stat_wr && wr_data[ACK_BIT];
    end

    assign interval    = wr_data[CNT_W-1:0];
    assign unused_bits = ^wr_data[MODE_BIT-1:CNT_W];
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter
    import ivt_pkg::*;
#(
    parameter int CNT_W = 29
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ivt_cmd_t         cmd,
    input  logic [CNT_W-1:0] interval,
    input  logic             tick,
    output logic             run,
    output logic             autoreload,
    output logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             pending,
    output logic             expire
);
    typedef struct packed {
        logic             run;
        logic             autoreload;
        logic [CNT_W-1:0] reload;
        logic [CNT_W-1:0] count;
        logic             pending;
    } state_t;

    state_t st_d, st_q;
    logic   expire_d;

    always_comb begin
        st_d     = st_q;
        expire_d = 1'b0;
        if (cmd.start) begin
            st_d.run        = 1'b1;
            st_d.autoreload = cmd.autoreload;
            st_d.reload     = interval;
            st_d.count      = interval;
        end else if (cmd.halt) begin
            st_d.run = 1'b0;
        end else if (st_q.run && tick) begin
            if (st_q.count == '0) begin
                expire_d = 1'b1;
                if (st_q.autoreload) begin
                    st_d.count = st_q.reload;
                end else begin
                    st_d.run = 1'b0;
                end
            end else begin
                st_d.count = st_q.count - 1'b1;
            end
        end
        if (cmd.ack) begin
            st_d.pending = 1'b0;
        end
        if (expire_d) begin
            st_d.pending = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run        = st_q.run;
    assign autoreload = st_q.autoreload;
    assign reload     = st_q.reload;
    assign count      = st_q.count;
    assign pending    = st_q.pending;
    assign expire     = expire_d;
endmodule

// File: rtl/ivt_read_mux.sv
module ivt_read_mux
    import ivt_pkg::*;
#(
    parameter int CNT_W = 29
) (
    input  logic              reg_sel,
    input  logic              run,
    input  logic              autoreload,
    input  logic [CNT_W-1:0]  reload,
    input  logic [CNT_W-1:0]  count,
    input  logic              pending,
    output logic [DATA_W-1:0] rd_data
);
    always_comb begin
        rd_data = '0;
        if (reg_sel == SEL_CTRL) begin
            rd_data[CNT_W-1:0] = reload;
            rd_data[MODE_BIT]  = autoreload;
            rd_data[RUN_BIT]   = run;
        end else begin
            rd_data[CNT_W-1:0] = count;
            rd_data[PEND_BIT]  = pending;
        end
    end
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
    import ivt_pkg::*;
#(
    parameter int CNT_W = 29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              tick,
    output logic              irq
);
    ivt_cmd_t         cmd;
    logic [CNT_W-1:0] interval;
    logic             run;
    logic             autoreload;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] count;
    logic             pending;
    logic             expire;

    ivt_bus_decode #(.CNT_W(CNT_W)) dec_i (
        .reg_sel  (reg_sel),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .cmd      (cmd),
        .interval (interval)
    );

    ivt_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (cmd),
        .interval   (interval),
        .tick       (tick),
        .run        (run),
        .autoreload (autoreload),
        .reload     (reload),
        .count      (count),
        .pending    (pending),
        .expire     (expire)
    );

    ivt_read_mux #(.CNT_W(CNT_W)) rmux_i (
        .reg_sel    (reg_sel),
        .run        (run),
        .autoreload (autoreload),
        .reload     (reload),
        .count      (count),
        .pending    (pending),
        .rd_data    (rd_data)
    );

    assign irq = pending;
endmodule

// File: rtl/ivt_timer_chk.sv
module ivt_timer_chk #(
    parameter int CNT_W = 29
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_sel,
    input logic             wr_en,
    input logic [31:0]      wr_data,
    input logic             tick,
    input logic             irq,
    input logic             run,
    input logic [CNT_W-1:0] count,
    input logic             expire
);
    logic ack_wr;
    assign ack_wr = wr_en && reg_sel && wr_data[30];

    a_r9_expire_beats_ack: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> irq);
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && !expire) |=> !irq);
    a_r11_level_held: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack_wr) |=> irq);
    a_r4_rise_only_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !expire) |=> !irq);
    a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick && !wr_en) |=> $stable(count));
    a_r7_halt_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !reg_sel && !wr_data[31]) |=> !run);
    a_r10_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !reg_sel && wr_data[31]) |=> (run && count == $past(wr_data[CNT_W-1:0])));
endmodule

bind ivt_timer ivt_timer_chk #(.CNT_W(CNT_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .reg_sel (reg_sel),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .tick    (tick),
    .irq     (irq),
    .run     (run),
    .count   (count),
    .expire  (expire)
);

// File: tb/ivt_timer_tb_top.sv
module ivt_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        tick = 1'b0;
    logic        irq;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    ivt_timer dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .reg_sel (reg_sel),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .tick    (tick),
        .irq     (irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=0x%08h expected=0x%08h", req, got, exp);
        end
    endtask

    task automatic bus_wr(input logic sel, input logic [31:0] data, input logic with_tick = 1'b0);
        @(negedge clk);
        reg_sel = sel; wr_data = data; wr_en = 1'b1; tick = with_tick;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic sel, output logic [31:0] v);
        reg_sel = sel;
        #1;
        v = rd_data;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
        end
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(1'b0, v); check("R1 ctrl after reset", v, 32'h0);
        rd(1'b1, v); check("R1 status after reset", v, 32'h0);
        check("R1 irq after reset", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_oneshot;
        logic [31:0] v;
        bus_wr(1'b0, 32'h8000_0004);
        rd(1'b0, v); check("R2 ctrl readback", v, 32'h8000_0004);
        rd(1'b1, v); check("R2 status count", v, 32'h0000_0004);
        idle(3);
        rd(1'b1, v); check("R3 count held without tick", v, 32'h0000_0004);
        ticks(2);
        rd(1'b1, v); check("R3 count after 2 ticks", v, 32'h0000_0002);
        ticks(2);
        check("R4 no irq before V+1 ticks", {31'b0, irq}, 32'h0);
        ticks(1);
        check("R4 irq after V+1 ticks", {31'b0, irq}, 32'h1);
        rd(1'b0, v); check("R5 run bit cleared", v[31], 1'b0);
        rd(1'b1, v); check("R12 pending in bit 30", v, 32'h4000_0000);
        idle(4);
        check("R11 irq held", {31'b0, irq}, 32'h1);
        bus_wr(1'b1, 32'hBFFF_FFFF);
        check("R8 ack without bit 30 ignored", {31'b0, irq}, 32'h1);
        bus_wr(1'b1, 32'h4000_0000);
        check("R8 ack clears", {31'b0, irq}, 32'h0);
        ticks(6);
        check("R5 no irq after one-shot", {31'b0, irq}, 32'h0);
        rd(1'b1, v); check("R5 count stays 0", v, 32'h0);
    endtask

    task automatic t_periodic;
        logic [31:0] v;
        bus_wr(1'b0, 32'hC000_0001);
        ticks(2);
        check("R6 first periodic irq", {31'b0, irq}, 32'h1);
        rd(1'b1, v); check("R6 reloaded count", v, 32'h4000_0001);
        bus_wr(1'b1, 32'h4000_0000);
        ticks(1);
        check("R6 no irq mid period", {31'b0, irq}, 32'h0);
        ticks(1);
        check("R6 second periodic irq", {31'b0, irq}, 32'h1);
        rd(1'b0, v); check("R6 run stays set", v, 32'hC000_0001);
        bus_wr(1'b1, 32'h4000_0000);
        ticks(1);
        // count now 0: expiry and ack in the same cycle
        rd(1'b1, v); check("R9 setup count zero", v, 32'h0);
        @(negedge clk);
        reg_sel = 1'b1; wr_data = 32'h4000_0000; wr_en = 1'b1; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0; wr_data = '0;
        check("R9 expiry beats ack", {31'b0, irq}, 32'h1);
        bus_wr(1'b1, 32'h4000_0000);
    endtask

    task automatic t_stop_restart;
        logic [31:0] v;
        bus_wr(1'b0, 32'h8000_0005);
        ticks(2);
        bus_wr(1'b0, 32'h0000_0000);
        rd(1'b1, v); check("R7 count frozen at stop", v, 32'h0000_0003);
        ticks(8);
        rd(1'b1, v); check("R7 count frozen after ticks", v, 32'h0000_0003);
        check("R7 no irq when stopped", {31'b0, irq}, 32'h0);
        rd(1'b0, v); check("R7 run bit clear", v[31], 1'b0);
        bus_wr(1'b0, 32'h8000_0005);
        ticks(1);
        bus_wr(1'b0, 32'h8000_0007, 1'b1);
        rd(1'b1, v); check("R10 start wins over tick", v, 32'h0000_0007);
        bus_wr(1'b0, 32'hBFFF_FFFF);
        rd(1'b0, v); check("R12 bit 29 ignored, max interval", v, 32'h9FFF_FFFF);
        rd(1'b1, v); check("R12 max count", v, 32'h1FFF_FFFF);
        ticks(1);
        rd(1'b1, v); check("R3 decrement from max", v, 32'h1FFF_FFFE);
        bus_wr(1'b0, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired got=0x00000000 expected=0x00000001");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle(2);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_oneshot();
        t_periodic();
        t_stop_restart();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule